// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a synchronous request port and an external asynchronous static RAM organised as 256K words of 16 bits. It turns one request into the full pin sequence the RAM expects. Each request carries a direction, an 18-bit word address, 16 bits of write data and a per-byte lane mask. The RAM has an active-low select, an active-high select, an output enable, a write enable and one active-low enable per byte lane. When the access is over, the controller raises a one-cycle completion pulse. For reads, it returns the captured word with any lane that was not requested forced to zero.

Every analog timing minimum of the RAM is a nanosecond parameter. The controller turns each one into a whole number of clock cycles by rounding up against the clock period, so one netlist can serve several speed grades and clock rates. A write ends on the rising edge of write enable. The controller drives the data bus only after a turnaround cycle in which the RAM's outputs are already disabled. A request with an empty lane mask finishes at once and never touches the RAM. Requests are taken only while the controller is idle, as shown by its ready output.

Top module: `sram_byte_ctrl`

## Requirements
- R1: While reset is applied, and at any idle time, the RAM is deselected: mem_cs_n=1, mem_cs=0, mem_oe_n=1, mem_we_n=1, mem_lane_n=2'b11, mem_dq_oe=0, rsp_done=0. An asynchronous reset during an access returns the pins to this state at once, and req_ready=1 afterwards.
- R2: A read with a non-empty mask keeps mem_cs_n=0, mem_cs=1, mem_oe_n=0 and mem_we_n=1 for 6 cycles at the default 10 ns clock, with the address on mem_addr. It samples mem_dq_in at the end of the sixth cycle. rsp_done is high for one cycle, in the 7th cycle after the accepting edge, with rsp_rdata valid in that cycle.
- R3: Mask bit 0 selects the lower lane (data bits 7:0, driven low on mem_lane_n[0]) and bit 1 selects the upper lane (bits 15:8, mem_lane_n[1]). rsp_rdata bytes of unselected lanes read as zero, and an active read or write never has both lane enables high.
- R4: mem_we_n is low only while mem_cs_n=0 and mem_cs=1. mem_oe_n stays high for the whole of a write.
- R5: During a write, mem_we_n is low for exactly 4 consecutive cycles at default timing. mem_dq_oe is high, with mem_dq_out equal to the request data, for all of those cycles and for the cycle in which mem_we_n returns high.
- R6: mem_dq_oe never rises while mem_oe_n is low. In a write it first goes high in the 2nd cycle after acceptance, after one cycle in which the selects are active, mem_oe_n is high and the bus is not driven.
- R7: mem_addr and mem_dq_out hold steady while mem_we_n is low. During an access mem_addr equals the accepted address.
- R8: A write occupies the RAM for 6 cycles (1 turnaround, 4 pulse, 1 recovery). rsp_done is high in the 7th cycle after the accepting edge, and the RAM holds the new bytes in the selected lanes only.
- R9: A request with mask 2'b00 asserts no select, drives no lane and raises rsp_done in the 1st cycle after the accepting edge.
- R10: req_ready is high only when idle. A request held on the port while an access is in progress is ignored: it starts no further access and does not change mem_addr.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_bmask | input | 2 | Lane mask, bit 0 lower byte, bit 1 upper byte |
| req_ready | output | 1 | Controller idle, request will be taken |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, unselected bytes zero |
| mem_addr | output | 18 | RAM address pins |
| mem_cs_n | output | 1 | Active-low RAM select |
| mem_cs | output | 1 | Active-high RAM select |
| mem_oe_n | output | 1 | Active-low RAM output enable |
| mem_we_n | output | 1 | Active-low RAM write enable |
| mem_lane_n | output | 2 | Active-low lane enables, bit 0 lower byte |
| mem_dq_out | output | 16 | Data toward the RAM |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out onto the pad |
| mem_dq_in | input | 16 | Data from the RAM |

## Verification
The bench uses a RAM model whose read data turns valid only in the sixth cycle of a stable read. A controller that samples one cycle early therefore returns a poison value rather than the stored word. Partial-lane writes followed by full-word and single-lane reads expose a swapped or ignored lane enable, because the wrong byte gets merged or a stale byte leaks into the result. The bench measures the write-enable pulse, the cycle in which the bus drive starts, and the handling of a request held during a busy access. A pulse that is too short, a missing turnaround cycle, or a controller that starts a second access would each show up as a wrong cycle count or a moving address. A reset in the middle of a write, and an empty-mask request, check that the pins fall back to the deselected state and that no select is ever pulsed for a no-op.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_SETUP,
    ST_RD_WAIT,
    ST_RD_CAPTURE,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_RECOVER
  } ctl_state_e;

  // Nanoseconds to whole clock cycles, rounded up.
  function automatic int ns_to_cyc(input int ns, input int period_ns);
    return (ns + period_ns - 1) / period_ns;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    return max2(max2(a, b), c);
  endfunction

endpackage

// File: rtl/sram_ctl_rst_sync.sv
module sram_ctl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;

endmodule

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int LANES       = 2,
  parameter int CNT_W       = 3,
  parameter int RD_WAIT_CYC = 5,
  parameter int TA_CYC      = 1,
  parameter int WP_CYC      = 4,
  parameter int REC_CYC     = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [LANES-1:0] req_bmask,
  input  logic [LANES-1:0] mask_q,
  input  logic             tmr_zero,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             accept,
  output logic             capture_en,
  output logic             ready,
  output logic             done,
  output logic             cs_n,
  output logic             cs,
  output logic             oe_n,
  output logic             we_n,
  output logic [LANES-1:0] lane_n,
  output logic             dq_oe
);

  ctl_state_e state_q, state_d;
  logic             done_d, done_q;
  logic             sel_d, oe_d, we_d, drv_d;
  logic [LANES-1:0] lane_d;
  logic [LANES-1:0] sel_mask;
  logic             cs_n_q, cs_q, oe_n_q, we_n_q, dq_oe_q;
  logic [LANES-1:0] lane_n_q;

  assign accept   = (state_q == ST_IDLE) && req_valid;
  assign sel_mask = accept ? req_bmask : mask_q;

  // Next-state and sequencing
  always_comb begin
    state_d    = state_q;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    capture_en = 1'b0;
    done_d     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (req_bmask == '0) begin
            done_d = 1'b1;
          end else if (req_write) begin
            state_d  = ST_WR_SETUP;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(TA_CYC - 1);
          end else begin
            state_d = ST_RD_SETUP;
          end
        end
      end
      ST_RD_SETUP: begin
        state_d  = ST_RD_WAIT;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(RD_WAIT_CYC - 1);
      end
      ST_RD_WAIT: begin
        if (tmr_zero) begin
          state_d    = ST_RD_CAPTURE;
          capture_en = 1'b1;
          done_d     = 1'b1;
        end
      end
      ST_RD_CAPTURE: begin
        state_d = ST_IDLE;
      end
      ST_WR_SETUP: begin
        if (tmr_zero) begin
          state_d  = ST_WR_PULSE;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(WP_CYC - 1);
        end
      end
      ST_WR_PULSE: begin
        if (tmr_zero) begin
          state_d  = ST_WR_RECOVER;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(REC_CYC - 1);
        end
      end
      ST_WR_RECOVER: begin
        if (tmr_zero) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  // Pin decode from the next state, registered below
  always_comb begin
    sel_d = 1'b0;
    oe_d  = 1'b0;
    we_d  = 1'b0;
    drv_d = 1'b0;
    unique case (state_d)
      ST_RD_SETUP, ST_RD_WAIT: begin
        sel_d = 1'b1;
        oe_d  = 1'b1;
      end
      ST_WR_SETUP: begin
        sel_d = 1'b1;
      end
      ST_WR_PULSE: begin
        sel_d = 1'b1;
        we_d  = 1'b1;
        drv_d = 1'b1;
      end
      ST_WR_RECOVER: begin
        sel_d = 1'b1;
        drv_d = 1'b1;
      end
      default: begin
        sel_d = 1'b0;
      end
    endcase
    lane_d = sel_d ? ~sel_mask : '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      done_q   <= 1'b0;
      cs_n_q   <= 1'b1;
      cs_q     <= 1'b0;
      oe_n_q   <= 1'b1;
      we_n_q   <= 1'b1;
      lane_n_q <= '1;
      dq_oe_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      done_q   <= done_d;
      cs_n_q   <= ~sel_d;
      cs_q     <= sel_d;
      oe_n_q   <= ~oe_d;
      we_n_q   <= ~we_d;
      lane_n_q <= lane_d;
      dq_oe_q  <= drv_d;
    end
  end

  assign ready  = (state_q == ST_IDLE);
  assign done   = done_q;
  assign cs_n   = cs_n_q;
  assign cs     = cs_q;
  assign oe_n   = oe_n_q;
  assign we_n   = we_n_q;
  assign lane_n = lane_n_q;
  assign dq_oe  = dq_oe_q;

endmodule

// File: rtl/sram_ctl_datapath.sv
module sram_ctl_datapath #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter int LANE_W = 8,
  parameter int LANES  = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture_en,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_bmask,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [LANES-1:0]  mask_q,
  output logic [DATA_W-1:0] rdata_q
);

  logic [DATA_W-1:0] rd_masked;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rd_masked[g*LANE_W +: LANE_W] =
      mask_q[g] ? mem_dq_in[g*LANE_W +: LANE_W] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      mask_q  <= req_bmask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (capture_en) begin
      rdata_q <= rd_masked;
    end
  end

endmodule

// File: rtl/sram_byte_ctrl.sv
module sram_byte_ctrl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int DATA_W    = 16,
  parameter int LANE_W    = 8,
  parameter int CLK_NS    = 10,
  parameter int T_AA_NS   = 55,
  parameter int T_OE_NS   = 25,
  parameter int T_RC_NS   = 55,
  parameter int T_WP_NS   = 35,
  parameter int T_AW_NS   = 40,
  parameter int T_DW_NS   = 25,
  parameter int T_WC_NS   = 55,
  parameter int T_OHZ_NS  = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic                       req_write,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [DATA_W-1:0]          req_wdata,
  input  logic [DATA_W/LANE_W-1:0]   req_bmask,
  output logic                       req_ready,
  output logic                       rsp_done,
  output logic [DATA_W-1:0]          rsp_rdata,
  output logic [ADDR_W-1:0]          mem_addr,
  output logic                       mem_cs_n,
  output logic                       mem_cs,
  output logic                       mem_oe_n,
  output logic                       mem_we_n,
  output logic [DATA_W/LANE_W-1:0]   mem_lane_n,
  output logic [DATA_W-1:0]          mem_dq_out,
  output logic                       mem_dq_oe,
  input  logic [DATA_W-1:0]          mem_dq_in
);

  localparam int LANES       = DATA_W / LANE_W;
  localparam int RD_ACC_CYC  = max3(ns_to_cyc(T_AA_NS, CLK_NS),
                                    ns_to_cyc(T_OE_NS, CLK_NS),
                                    ns_to_cyc(T_RC_NS, CLK_NS));
  localparam int RD_WAIT_CYC = max2(1, RD_ACC_CYC - 1);
  localparam int TA_CYC      = max2(1, ns_to_cyc(T_OHZ_NS, CLK_NS));
  localparam int WP_CYC      = max3(ns_to_cyc(T_WP_NS, CLK_NS),
                                    ns_to_cyc(T_DW_NS, CLK_NS),
                                    ns_to_cyc(T_AW_NS, CLK_NS) - TA_CYC);
  localparam int REC_CYC     = max2(1, ns_to_cyc(T_WC_NS, CLK_NS) - TA_CYC - WP_CYC);
  localparam int MAX_CYC     = max3(max2(RD_WAIT_CYC, TA_CYC), WP_CYC, REC_CYC);
  localparam int CNT_W       = max2(1, $clog2(MAX_CYC + 1));

  logic             rst_sync_n;
  logic             tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  logic             accept, capture_en;
  logic [LANES-1:0] mask_q;

  sram_ctl_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sram_ctl_timer #(
    .CNT_W (CNT_W)
  ) i_timer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  sram_ctl_fsm #(
    .LANES       (LANES),
    .CNT_W       (CNT_W),
    .RD_WAIT_CYC (RD_WAIT_CYC),
    .TA_CYC      (TA_CYC),
    .WP_CYC      (WP_CYC),
    .REC_CYC     (REC_CYC)
  ) i_fsm (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_bmask  (req_bmask),
    .mask_q     (mask_q),
    .tmr_zero   (tmr_zero),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val),
    .accept     (accept),
    .capture_en (capture_en),
    .ready      (req_ready),
    .done       (rsp_done),
    .cs_n       (mem_cs_n),
    .cs         (mem_cs),
    .oe_n       (mem_oe_n),
    .we_n       (mem_we_n),
    .lane_n     (mem_lane_n),
    .dq_oe      (mem_dq_oe)
  );

  sram_ctl_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LANE_W (LANE_W),
    .LANES  (LANES)
  ) i_datapath (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .accept     (accept),
    .capture_en (capture_en),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_bmask  (req_bmask),
    .mem_dq_in  (mem_dq_in),
    .addr_q     (mem_addr),
    .wdata_q    (mem_dq_out),
    .mask_q     (mask_q),
    .rdata_q    (rsp_rdata)
  );

endmodule

// File: rtl/sram_ctl_checker.sv
module sram_ctl_checker #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter int LANES  = 2,
  parameter int WP_CYC = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_done,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs_n,
  input logic              mem_cs,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic [LANES-1:0]  mem_lane_n,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_dq_oe
);

  localparam int LW = $clog2(WP_CYC + 2) + 1;

  logic [LW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
    end else if (!mem_we_n) begin
      low_cnt <= low_cnt + 1'b1;
    end else begin
      low_cnt <= '0;
    end
  end

  assert_we_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cs_n && mem_cs));

  assert_we_oe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);

  assert_pulse_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (low_cnt == LW'(WP_CYC)));

  assert_no_contention_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  assert_turnaround_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> ($past(mem_oe_n) && !$past(mem_cs_n) && !$past(mem_dq_oe)));

  assert_hold_during_we_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

  assert_lane_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs_n |-> !(&mem_lane_n));

  assert_ready_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && !mem_cs && mem_we_n && !mem_dq_oe));

  assert_done_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (mem_we_n && mem_oe_n));

endmodule

bind sram_byte_ctrl sram_ctl_checker #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .LANES  (LANES),
  .WP_CYC (WP_CYC)
) i_sram_ctl_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .rsp_done   (rsp_done),
  .mem_addr   (mem_addr),
  .mem_cs_n   (mem_cs_n),
  .mem_cs     (mem_cs),
  .mem_oe_n   (mem_oe_n),
  .mem_we_n   (mem_we_n),
  .mem_lane_n (mem_lane_n),
  .mem_dq_out (mem_dq_out),
  .mem_dq_oe  (mem_dq_oe)
);

// File: tb/test_sram_byte_ctrl.sv
`timescale 1ns/1ps
module test_sram_byte_ctrl;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_write;
  logic [17:0] req_addr;
  logic [15:0] req_wdata;
  logic [1:0]  req_bmask;
  logic        req_ready;
  logic        rsp_done;
  logic [15:0] rsp_rdata;
  logic [17:0] mem_addr;
  logic        mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [1:0]  mem_lane_n;
  logic [15:0] mem_dq_out;
  logic [15:0] mem_dq_in;

  int n_chk = 0;
  int n_fail = 0;

  sram_byte_ctrl i_sram_byte_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_bmask(req_bmask),
    .req_ready(req_ready), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_cs(mem_cs),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_lane_n(mem_lane_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // RAM model: 64 words, data valid only in the 6th cycle of a stable read
  logic [15:0] ram [64];
  int          act_cnt;
  logic        rd_active;

  initial begin
    for (int i = 0; i < 64; i++) ram[i] = 16'h1000 + 16'(i);
  end

  assign rd_active = !mem_cs_n && mem_cs && !mem_oe_n && mem_we_n && !(&mem_lane_n);

  always @(posedge clk) begin
    if (rd_active) act_cnt <= act_cnt + 1;
    else act_cnt <= 0;
  end

  always_comb begin
    if (rd_active && act_cnt >= 5) begin
      mem_dq_in[7:0]  = mem_lane_n[0] ? 8'hEE : ram[mem_addr[5:0]][7:0];
      mem_dq_in[15:8] = mem_lane_n[1] ? 8'hEE : ram[mem_addr[5:0]][15:8];
    end else begin
      mem_dq_in = 16'hBAD0;
    end
  end

  always @(posedge mem_we_n) begin
    if (!mem_cs_n && mem_cs && mem_dq_oe) begin
      if (!mem_lane_n[0]) ram[mem_addr[5:0]][7:0]  = mem_dq_out[7:0];
      if (!mem_lane_n[1]) ram[mem_addr[5:0]][15:8] = mem_dq_out[15:8];
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Per-operation observations
  int          o_lat, o_we_low, o_drv_first, o_addr_err, o_oe_err, o_lane_err, o_sel;
  logic        o_ready1;
  logic [15:0] o_rd;

  task automatic do_op(input logic w, input logic [17:0] a, input logic [15:0] d,
                       input logic [1:0] m);
    o_lat = -1; o_we_low = 0; o_drv_first = 0; o_addr_err = 0;
    o_oe_err = 0; o_lane_err = 0; o_sel = 0; o_ready1 = 1'b0; o_rd = '0;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_bmask = m;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 1; k <= 40; k++) begin
      if (k == 1) o_ready1 = req_ready;
      if (!mem_we_n) o_we_low++;
      if (mem_dq_oe && o_drv_first == 0) o_drv_first = k;
      if (!mem_cs_n || mem_cs) o_sel++;
      if (!mem_cs_n && mem_addr != a) o_addr_err++;
      if (w && !mem_oe_n) o_oe_err++;
      if (!mem_cs_n && mem_lane_n != ~m) o_lane_err++;
      if (rsp_done) begin
        o_lat = k;
        o_rd = rsp_rdata;
        break;
      end
      @(negedge clk);
    end
  endtask

  // {write, addr, wdata, mask, expected read data}
  localparam int NVEC = 12;
  localparam logic [52:0] VEC [NVEC] = '{
    {1'b1, 18'h00005, 16'hA1B2, 2'b11, 16'h0000},
    {1'b0, 18'h00005, 16'h0000, 2'b11, 16'hA1B2},
    {1'b1, 18'h00005, 16'h3344, 2'b01, 16'h0000},
    {1'b0, 18'h00005, 16'h0000, 2'b11, 16'hA144},
    {1'b1, 18'h00005, 16'h5566, 2'b10, 16'h0000},
    {1'b0, 18'h00005, 16'h0000, 2'b10, 16'h5500},
    {1'b0, 18'h00005, 16'h0000, 2'b01, 16'h0044},
    {1'b0, 18'h3FFC7, 16'h0000, 2'b11, 16'h1007},
    {1'b1, 18'h3FFFF, 16'hBEEF, 2'b11, 16'h0000},
    {1'b0, 18'h3FFFF, 16'h0000, 2'b11, 16'hBEEF},
    {1'b1, 18'h00005, 16'hFFFF, 2'b00, 16'h0000},
    {1'b0, 18'h00005, 16'h0000, 2'b11, 16'h5544}
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0; req_bmask = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk({mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_lane_n, mem_dq_oe, rsp_done} == 8'b1011_1100,
        "R1", "pins in reset", {mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_lane_n, mem_dq_oe, rsp_done},
        8'b1011_1100);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    chk({mem_cs_n, mem_cs, mem_we_n, mem_dq_oe} == 4'b1010, "R1", "idle pins",
        {mem_cs_n, mem_cs, mem_we_n, mem_dq_oe}, 4'b1010);

    // Table walk
    for (int v = 0; v < NVEC; v++) begin
      logic        w;
      logic [17:0] a;
      logic [15:0] d, e;
      logic [1:0]  m;
      w = VEC[v][52]; a = VEC[v][51:34]; d = VEC[v][33:18]; m = VEC[v][17:16]; e = VEC[v][15:0];
      do_op(w, a, d, m);
      if (m == 2'b00) begin
        chk(o_lat == 1, "R9", "no-op done latency", o_lat, 1);
        chk(o_sel == 0, "R9", "no-op select cycles", o_sel, 0);
      end else if (w) begin
        chk(o_lat == 7, "R8", "write done latency", o_lat, 7);
        chk(o_we_low == 4, "R5", "write pulse cycles", o_we_low, 4);
        chk(o_drv_first == 2, "R6", "first drive cycle", o_drv_first, 2);
        chk(o_oe_err == 0, "R4", "oe low during write", o_oe_err, 0);
        chk(o_ready1 == 1'b0, "R10", "ready while busy", o_ready1, 0);
      end else begin
        chk(o_lat == 7, "R2", "read done latency", o_lat, 7);
        chk(o_rd == e, "R2", "read data", o_rd, e);
        chk(o_we_low == 0, "R2", "we low during read", o_we_low, 0);
        chk(o_drv_first == 0, "R6", "bus driven during read", o_drv_first, 0);
      end
      chk(o_addr_err == 0, "R7", "address during access", o_addr_err, 0);
      chk(o_lane_err == 0, "R3", "lane enables", o_lane_err, 0);
    end

    // R10: request held during a busy read is ignored
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 18'h00005; req_bmask = 2'b11;
    @(negedge clk);
    req_write = 1'b1; req_addr = 18'h00009; req_wdata = 16'h7777;
    chk(req_ready == 1'b0, "R10", "ready in busy read", req_ready, 0);
    repeat (3) @(negedge clk);
    chk(mem_addr == 18'h00005, "R10", "address while busy", mem_addr, 18'h00005);
    req_valid = 1'b0;
    o_lat = -1;
    for (int k = 0; k < 20; k++) begin
      if (rsp_done) begin o_lat = k; o_rd = rsp_rdata; break; end
      @(negedge clk);
    end
    chk(o_rd == 16'h5544, "R10", "read result with held request", o_rd, 16'h5544);
    o_sel = 0;
    repeat (4) begin
      @(negedge clk);
      if (!mem_cs_n || rsp_done) o_sel++;
    end
    chk(o_sel == 0, "R10", "extra access after ignored request", o_sel, 0);
    chk(ram[9] == 16'h1009, "R10", "ignored write changed RAM", ram[9], 16'h1009);

    // R1: reset in the middle of a write pulse
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 18'h00020; req_wdata = 16'h0F0F; req_bmask = 2'b11;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk(mem_we_n == 1'b0, "R5", "pulse active before reset", mem_we_n, 0);
    rst_n = 1'b0;
    #1;
    chk({mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_lane_n, mem_dq_oe} == 7'b1011_110,
        "R1", "pins after async reset", {mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_lane_n, mem_dq_oe},
        7'b1011_110);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready after mid-write reset", req_ready, 1);

    // R8: a write after reset lands in the selected lane only
    do_op(1'b1, 18'h00021, 16'hCAFE, 2'b10);
    chk(o_lat == 7, "R8", "write latency after reset", o_lat, 7);
    chk(ram[33] == 16'hCA21, "R8", "upper-lane write merge", ram[33], 16'hCA21);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule